// File: doc/BRIEF.md
# Asynchronous Nonvolatile SRAM Bus Controller

This block sits between a synchronous host and an asynchronous battery-backed SRAM that also holds a timekeeping function. The host hands it one request at a time over a valid/ready port: an address, a write/read flag and write data. The controller then drives the memory's active-low chip-enable, output-enable and write-enable strobes with cycle counts that stand in for the memory's access, data-setup, data-hold and recovery times. It returns one response per request, which carries read data and an error flag.

The memory data bus is split into an outgoing value with its own enable and an incoming value, so a pad ring or a bench model can form the bidirectional bus. Output-enable is never active while the controller drives data. Every cycle is followed by a recovery gap with all strobes inactive. An active-low power-fail input stops new cycles from starting. If power fails during a cycle, that cycle is cut short and the host gets an error response for it. The power-fail input is taken as already synchronous to the controller clock.

Top module: `nvram_bus_ctrl`

## Requirements
- R1: After reset the three strobes are high, the data-out enable is low, no response is pending, and ready is high once power-fail is high.
- R2: A read holds chip-enable and output-enable low and write-enable high for exactly the longest of T_AA, T_CEA and T_OEA cycles. It samples the memory data at the end of the last of these cycles and returns that data with a one-cycle response pulse and the error flag clear.
- R3: A write holds chip-enable and write-enable low together for exactly T_SETUP cycles with output-enable high. The data-out enable is high in every cycle in which write-enable is low.
- R4: After write-enable returns high, the data-out enable and the outgoing data stay asserted for exactly T_HOLD more cycles and are then released.
- R5: The memory address does not change while chip-enable is low or the data-out enable is high.
- R6: Between the end of one cycle and the fall of chip-enable for the next, all strobes stay high for at least T_REC cycles. Ready stays low during this gap.
- R7: Output-enable and the data-out enable are never both active in the same cycle.
- R8: While power-fail is low in the idle state, ready is low and no cycle starts, even if a request is waiting.
- R9: If power-fail is low during a read, the strobes go high in the next cycle and the response carries the error flag. If it is low during a write, write-enable goes high at once, the hold phase still runs in full, and the response carries the error flag.
- R10: Each accepted request yields exactly one response pulse, and ready is high only in the idle state with the strobes inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Request was cut short by power failure |
| rsp_rdata | output | DATA_W | Read data (zero for writes and failed reads) |
| pwr_fail_n | input | 1 | Active-low power-fail indication |
| mem_addr | output | ADDR_W | Memory address |
| mem_dout | output | DATA_W | Data driven toward the memory |
| mem_doe | output | 1 | Enable for mem_dout onto the bus |
| mem_din | input | DATA_W | Data returned by the memory |
| mem_ce_n | output | 1 | Active-low chip-enable |
| mem_oe_n | output | 1 | Active-low output-enable |
| mem_we_n | output | 1 | Active-low write-enable |

## Verification
The assertions assume that power-fail and the host request inputs change only between clock edges and are stable at each edge. They also assume every timing parameter is at least 1. The bench drives all inputs on the falling clock edge. It presents a request only once ready is seen high, and it takes power-fail low only for whole clock cycles, either while the controller is idle or at a chosen cycle inside a read or a write. The memory model returns a poisoned value until the read has been active long enough. It commits a write only when write-enable was low for the full setup count, so a shortened phase shows up as wrong data.

// File: rtl/nvram_ctrl_pkg.sv
package nvram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RD    = 3'd1,
    ST_WSET  = 3'd2,
    ST_WHOLD = 3'd3,
    ST_REC   = 3'd4
  } bus_state_t;

  // largest of three wait counts
  function automatic int longest3(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

  // counter value to load so that a phase lasts n cycles
  function automatic int phase_load(input int n);
    return (n > 0) ? n - 1 : 0;
  endfunction

endpackage

// File: rtl/nvram_phase_timer.sv
module nvram_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/nvram_strobe_decode.sv
module nvram_strobe_decode
  import nvram_ctrl_pkg::*;
(
  input  bus_state_t st,
  output logic       ce_n,
  output logic       oe_n,
  output logic       we_n,
  output logic       doe
);
  always_comb begin
    ce_n = 1'b1;
    oe_n = 1'b1;
    we_n = 1'b1;
    doe  = 1'b0;
    unique case (st)
      ST_RD:    begin ce_n = 1'b0; oe_n = 1'b0; end
      ST_WSET:  begin ce_n = 1'b0; we_n = 1'b0; doe = 1'b1; end
      ST_WHOLD: doe = 1'b1;
      default:  ;
    endcase
  end
endmodule

// File: rtl/nvram_bus_ctrl.sv
module nvram_bus_ctrl
  import nvram_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int T_AA    = 4,
  parameter int T_CEA   = 3,
  parameter int T_OEA   = 2,
  parameter int T_SETUP = 3,
  parameter int T_HOLD  = 2,
  parameter int T_REC   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              pwr_fail_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_doe,
  input  logic [DATA_W-1:0] mem_din,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n
);
  localparam int T_RD  = longest3(T_AA, T_CEA, T_OEA);
  localparam int T_MAX = longest3(T_RD, longest3(T_SETUP, T_HOLD, T_REC), 1);
  localparam int CW    = $clog2(T_MAX + 1) + 1;

  bus_state_t st, st_nxt;
  logic          ld;
  logic [CW-1:0] ld_val;
  logic          t_done;
  logic          accept, finish, capture, fail_seen, busy;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  nvram_phase_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ld_val), .done(t_done)
  );

  nvram_strobe_decode u_dec (
    .st(st), .ce_n(mem_ce_n), .oe_n(mem_oe_n), .we_n(mem_we_n), .doe(mem_doe)
  );

  // named events
  assign req_ready = (st == ST_IDLE) && pwr_fail_n;
  assign accept    = req_valid && req_ready;
  assign busy      = (st == ST_RD) || (st == ST_WSET) || (st == ST_WHOLD);

  always_comb begin
    st_nxt  = st;
    ld      = 1'b0;
    ld_val  = '0;
    finish  = 1'b0;
    capture = 1'b0;
    unique case (st)
      ST_IDLE: if (accept) begin
        ld     = 1'b1;
        st_nxt = req_write ? ST_WSET : ST_RD;
        ld_val = req_write ? CW'(phase_load(T_SETUP)) : CW'(phase_load(T_RD));
      end
      ST_RD: if (!pwr_fail_n || t_done) begin
        st_nxt  = ST_REC;
        ld      = 1'b1;
        ld_val  = CW'(phase_load(T_REC));
        finish  = 1'b1;
        capture = pwr_fail_n;
      end
      ST_WSET: if (!pwr_fail_n || t_done) begin
        st_nxt = ST_WHOLD;
        ld     = 1'b1;
        ld_val = CW'(phase_load(T_HOLD));
      end
      ST_WHOLD: if (t_done) begin
        st_nxt = ST_REC;
        ld     = 1'b1;
        ld_val = CW'(phase_load(T_REC));
        finish = 1'b1;
      end
      ST_REC:  if (t_done) st_nxt = ST_IDLE;
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      addr_q    <= '0;
      wdata_q   <= '0;
      fail_seen <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      st        <= st_nxt;
      rsp_valid <= finish;
      if (accept) begin
        addr_q    <= req_addr;
        wdata_q   <= req_wdata;
        fail_seen <= 1'b0;
      end else if (busy && !pwr_fail_n) begin
        fail_seen <= 1'b1;
      end
      if (finish) begin
        rsp_err   <= fail_seen || !pwr_fail_n;
        rsp_rdata <= capture ? mem_din : '0;
      end
    end
  end

  assign mem_addr = addr_q;
  assign mem_dout = wdata_q;

  // recovery-gap observer for the checks below
  logic [CW-1:0] gap_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                        gap_cnt <= CW'(T_REC);
    else if (!mem_ce_n)                                gap_cnt <= '0;
    else if (mem_we_n && gap_cnt < CW'(T_REC))         gap_cnt <= gap_cnt + 1'b1;
  end

  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_doe && !mem_oe_n)); // R7
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((!mem_ce_n || mem_doe) && $past(!mem_ce_n || mem_doe)) |-> $stable(mem_addr)); // R5
  AST_WE_NEEDS_DOE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_doe); // R3
  AST_PF_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_fail_n && st == ST_IDLE) |=> mem_ce_n); // R8
  AST_RECOVERY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> (gap_cnt >= CW'(T_REC))); // R6
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_doe)); // R10
  AST_SINGLE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R10
  AST_PF_READ_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_fail_n && st == ST_RD) |=> (mem_ce_n && rsp_valid && rsp_err)); // R9

endmodule

// File: tb/nvram_bus_ctrl_test.sv
module nvram_bus_ctrl_test;
  localparam int AW = 16, DW = 8;
  localparam int P_AA = 4, P_CEA = 3, P_OEA = 2, P_SET = 3, P_HLD = 2, P_REC = 3;
  // read wait restated: address access dominates the other two here
  localparam int EXP_RD = (P_AA >= P_CEA && P_AA >= P_OEA) ? P_AA :
                          ((P_CEA >= P_OEA) ? P_CEA : P_OEA);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, pwr_fail_n = 1'b1;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err, mem_doe, mem_ce_n, mem_oe_n, mem_we_n;
  logic [DW-1:0] rsp_rdata, mem_dout, mem_din;
  logic [AW-1:0] mem_addr;

  always #10 clk = ~clk;

  nvram_bus_ctrl #(.ADDR_W(AW), .DATA_W(DW), .T_AA(P_AA), .T_CEA(P_CEA), .T_OEA(P_OEA),
    .T_SETUP(P_SET), .T_HOLD(P_HLD), .T_REC(P_REC)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .pwr_fail_n(pwr_fail_n), .mem_addr(mem_addr), .mem_dout(mem_dout),
    .mem_doe(mem_doe), .mem_din(mem_din), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n));

  int checks = 0, errors = 0;
  bit pf_test = 1'b0, finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [DW-1:0] mem [256];
  int rd_cnt = 0, wr_cnt = 0;
  logic [7:0] w_a;
  logic [DW-1:0] w_d;
  initial for (int i = 0; i < 256; i++) mem[i] = 8'h00;
  assign mem_din = (rd_cnt >= EXP_RD - 1) ? mem[mem_addr[7:0]] : 8'hEE;
  always @(posedge clk) begin
    if (!mem_ce_n && !mem_oe_n) rd_cnt <= rd_cnt + 1; else rd_cnt <= 0;
    if (!mem_ce_n && !mem_we_n) begin
      wr_cnt <= wr_cnt + 1; w_a <= mem_addr[7:0]; w_d <= mem_dout;
    end else if (wr_cnt != 0) begin
      if (wr_cnt >= P_SET) mem[w_a] <= w_d;
      wr_cnt <= 0;
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct { bit rd; bit err; logic [DW-1:0] data; } exp_t;
  exp_t sbq[$];
  logic [DW-1:0] shadow [256];
  initial for (int i = 0; i < 256; i++) shadow[i] = 8'h00;

  task automatic do_req(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input int pf);
    exp_t e;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    e.rd = !w; e.err = (pf > 0); e.data = shadow[a[7:0]];
    if (w && pf == 0) shadow[a[7:0]] = d;
    pf_test = (pf > 0);
    sbq.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
    if (pf > 0) begin
      repeat (pf - 1) @(negedge clk);
      pwr_fail_n = 1'b0;
      repeat (2) @(negedge clk);
      pwr_fail_n = 1'b1;
    end
    while (sbq.size() != 0) @(negedge clk);
    repeat (P_REC + 1) @(negedge clk);
    pf_test = 1'b0;
  endtask

  // monitor: responses and bus timing, sampled on falling edge
  int rd_run = 0, wr_run = 0, hold_run = 0, gap = 100;
  logic prev_ce = 1'b1, prev_doe = 1'b0, prev_act = 1'b0;
  logic [AW-1:0] held_addr = '0;
  always @(negedge clk) if (rst_n) begin
    if (rsp_valid) begin
      if (sbq.size() == 0) chk(1'b0, "R10 unexpected response", 1, 0);
      else begin
        exp_t e;
        e = sbq.pop_front();
        chk(rsp_err == e.err, "R9 response error flag", int'(rsp_err), int'(e.err));
        if (e.rd && !e.err)
          chk(rsp_rdata == e.data, "R2 read data", int'(rsp_rdata), int'(e.data));
      end
    end
    // R2 read strobe width
    if (!mem_ce_n && !mem_oe_n) begin
      rd_run++;
      chk(mem_we_n == 1'b1, "R2 we high in read", int'(mem_we_n), 1);
    end else if (rd_run > 0) begin
      if (!pf_test) chk(rd_run == EXP_RD, "R2 read width", rd_run, EXP_RD);
      rd_run = 0;
    end
    // R3 write strobe width
    if (!mem_ce_n && !mem_we_n) begin
      wr_run++;
      chk(mem_doe && mem_oe_n, "R3 doe high oe high in write", int'({mem_doe, mem_oe_n}), 3);
    end else if (wr_run > 0) begin
      if (!pf_test) chk(wr_run == P_SET, "R3 write width", wr_run, P_SET);
      wr_run = 0;
    end
    // R4 hold
    if (mem_doe && mem_we_n) hold_run++;
    if (prev_doe && !mem_doe) begin
      chk(hold_run == P_HLD, "R4 hold length", hold_run, P_HLD);
      hold_run = 0;
    end
    // R7 contention
    if (mem_doe && !mem_oe_n) chk(1'b0, "R7 bus fight", 1, 0);
    // R5 address stability
    if (!mem_ce_n || mem_doe) begin
      if (prev_act) chk(mem_addr == held_addr, "R5 address held", int'(mem_addr), int'(held_addr));
      held_addr = mem_addr;
    end
    // R6 recovery gap
    if (!mem_ce_n && prev_ce) chk(gap >= P_REC, "R6 recovery gap", gap, P_REC);
    if (req_ready) begin
      chk(gap >= P_REC, "R6 ready after recovery", gap, P_REC);
      chk(mem_ce_n && mem_we_n && !mem_doe, "R10 ready only when quiet", 0, 1);
    end
    if (!mem_ce_n) gap = 0;
    else if (mem_we_n && !mem_doe) gap++;
    prev_act = !mem_ce_n || mem_doe;
    prev_ce  = mem_ce_n;
    prev_doe = mem_doe;
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes high in reset",
        int'({mem_ce_n, mem_oe_n, mem_we_n}), 7);
    chk(!mem_doe, "R1 doe low in reset", int'(mem_doe), 0);
    chk(!rsp_valid, "R1 no response in reset", int'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R1 ready after reset", int'(req_ready), 1);

    // R2 R3 R4: several data patterns
    do_req(1'b1, 16'h0010, 8'hA5, 0);
    do_req(1'b1, 16'h00FF, 8'h5A, 0);
    do_req(1'b1, 16'h1203, 8'hFF, 0);
    do_req(1'b0, 16'h0010, 8'h00, 0);
    do_req(1'b0, 16'h00FF, 8'h00, 0);
    do_req(1'b0, 16'h1203, 8'h00, 0);
    do_req(1'b1, 16'h0010, 8'h00, 0);
    do_req(1'b0, 16'h0010, 8'h00, 0);
    do_req(1'b0, 16'h0044, 8'h00, 0);

    // R8: power fail while idle blocks a waiting request
    @(negedge clk);
    pwr_fail_n = 1'b0;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0020; req_wdata = 8'h77;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(!req_ready, "R8 ready low under power fail", int'(req_ready), 0);
      chk(mem_ce_n && mem_we_n, "R8 no cycle under power fail", int'(mem_ce_n), 1);
    end
    req_valid = 1'b0;
    pwr_fail_n = 1'b1;
    do_req(1'b0, 16'h0020, 8'h00, 0);
    chk(mem[8'h20] == 8'h00, "R8 blocked write left memory", int'(mem[8'h20]), 0);

    // R9: power fail inside a read and inside a write
    do_req(1'b0, 16'h0010, 8'h00, 2);
    do_req(1'b1, 16'h0030, 8'h3C, 1);
    do_req(1'b1, 16'h0031, 8'hC3, 4);
    do_req(1'b0, 16'h00FF, 8'h00, 0);

    chk(sbq.size() == 0, "R10 all responses seen", sbq.size(), 0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R10 watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule